// File: doc/BRIEF.md
# Prioritized Timer Interrupt Vector Generator

This block holds the interrupt flags of a capture/compare timer with seven channels and one overflow source, and turns them into two interrupt requests. Channel 0 has a dedicated request of its own. The processor's acknowledge of that request clears the channel 0 flag. The overflow flag and the flags of channels 1 to 6 are merged into one shared request. A registered vector value names the most urgent source of that shared request.

Capture and compare events arrive as one-cycle pulses for each channel, and the counter overflow arrives as a single pulse. Software can read the flags and overwrite them with a single write strobe. A service routine reads or writes the vector. Each such access clears only the flag that the vector names in that cycle. Any other pending flags stay set, so the shared request comes back straight away.

The block holds no sequential control beyond the flag bits and the vector register. Every flag is an independent set/clear cell with a fixed precedence order.

Top module: `tmr_irq_vector`

## Requirements
- R1: After reset is asserted, all flags read 0, the vector reads 0 and both requests are low.
- R2: A capture or compare pulse on channel n sets flag bit n at the next clock edge. An overflow pulse sets flag bit 7.
- R3: When the software write strobe is high, every flag bit is loaded from the write data in that cycle. Bit n is channel n and bit 7 is overflow.
- R4: The dedicated request is high exactly when the global enable, enable bit 0 and flag bit 0 are all high. The shared request is high exactly when the global enable is high and some bit k in 1 to 7 has both its flag and its enable set.
- R5: An acknowledge of the dedicated request clears flag bit 0 at the next edge.
- R6: The vector reads 0 when no shared source is pending and enabled. Otherwise it reads 2n for channel n (n from 1 to 6) or 14 for overflow. The lowest pending enabled channel number wins and overflow has the lowest rank. Channel 0 and disabled sources never affect it. It is registered: it reflects the flags of the same cycle and the enables sampled at the previous edge.
- R7: An access to the vector clears, at the next edge, only the source whose code the vector shows in the access cycle. An access while the vector reads 0 clears nothing.
- R8: A set event on a bit wins over every clear of that bit in the same cycle: software write of 0, acknowledge or vector access.
- R9: A software write wins over an acknowledge or vector access clear in the same cycle.
- R10: A vector access never changes flag bit 0, and the acknowledge never changes bits 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cap_evt | input | 7 | Capture pulse for each channel |
| cmp_evt | input | 7 | Compare-match pulse for each channel |
| ovf_evt | input | 1 | Counter overflow pulse |
| sw_flag_wr | input | 1 | Software write strobe for the flag register |
| sw_flag_wdata | input | 8 | Flag write data (bit 7 = overflow) |
| src_ie | input | 8 | Local enables (bit 7 = overflow) |
| gie | input | 1 | Global interrupt enable |
| ch0_ack | input | 1 | Dedicated request accepted |
| vec_acc | input | 1 | Read or write access to the vector |
| flags | output | 8 | Current flag bits |
| vec_out | output | 4 | Registered shared-interrupt vector |
| irq_ch0 | output | 1 | Dedicated request for channel 0 |
| irq_shared | output | 1 | Shared request |

## Verification
The critical overlap is a vector access or an acknowledge in the same cycle as a new set event or a software write on the same bit. Such an overlap also occurs when a new higher-ranked source arrives in the very cycle the vector is accessed. Random stimulus fires events, writes, acknowledges and accesses independently every cycle, so these overlaps occur many times. Directed steps force the access-plus-event and access-with-two-pending cases. A bench model applies the precedence set over write over clear and the clear-what-was-shown rule. It then compares flags, vector and both requests every cycle.

// File: rtl/tivg_pkg.sv
package tivg_pkg;

    // Vector code spacing: source k is reported as STEP*k
    localparam int TIVG_STEP = 2;

    function automatic int tivg_code(input int k);
        return TIVG_STEP * k;
    endfunction

endpackage

// File: rtl/tivg_flag_cell.sv
module tivg_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic auto_clr,
    output logic flag_d,
    output logic flag_q
);

    // precedence: hardware set, then software write, then automatic clear
    always_comb begin
        if (set_evt)
            flag_d = 1'b1;
        else if (sw_wr)
            flag_d = sw_val;
        else if (auto_clr)
            flag_d = 1'b0;
        else
            flag_d = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= flag_d;
    end

    // R8: a set event survives any simultaneous clear
    a_r8_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q);

    // R5 / R7: an undisturbed automatic clear takes effect
    a_r5_r7_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr && !set_evt && !sw_wr) |=> !flag_q);

endmodule

// File: rtl/tivg_prio_enc.sv
module tivg_prio_enc #(
    parameter int NSH = 7,
    parameter int VW  = 4
) (
    input  logic [NSH-1:0] pend,
    output logic [VW-1:0]  code
);
    import tivg_pkg::*;

    // pend[i] is source i+1; lower index ranks higher
    always_comb begin
        code = '0;
        for (int i = NSH - 1; i >= 0; i--) begin
            if (pend[i])
                code = VW'(tivg_code(i + 1));
        end
    end

endmodule

// File: rtl/tmr_irq_vector.sv
module tmr_irq_vector #(
    parameter int NCH = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0]                cap_evt,
    input  logic [NCH-1:0]                cmp_evt,
    input  logic                          ovf_evt,
    input  logic                          sw_flag_wr,
    input  logic [NCH:0]                  sw_flag_wdata,
    input  logic [NCH:0]                  src_ie,
    input  logic                          gie,
    input  logic                          ch0_ack,
    input  logic                          vec_acc,
    output logic [NCH:0]                  flags,
    output logic [$clog2(2*NCH+1)-1:0]    vec_out,
    output logic                          irq_ch0,
    output logic                          irq_shared
);
    import tivg_pkg::*;

    localparam int NSRC = NCH + 1;
    localparam int VW   = $clog2(2 * NCH + 1);

    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] flag_d;
    logic [NSRC-1:0] flag_q;
    logic [VW-1:0]   enc_code;
    logic [VW-1:0]   vec_q;

    assign set_vec = {ovf_evt, cap_evt | cmp_evt};

    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_src
            if (k == 0) begin : g_dedicated
                assign clr_vec[k] = ch0_ack;
            end else begin : g_shared
                assign clr_vec[k] = vec_acc && (vec_q == VW'(tivg_code(k)));
            end
            tivg_flag_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_evt  (set_vec[k]),
                .sw_wr    (sw_flag_wr),
                .sw_val   (sw_flag_wdata[k]),
                .auto_clr (clr_vec[k]),
                .flag_d   (flag_d[k]),
                .flag_q   (flag_q[k])
            );
        end
    endgenerate

    tivg_prio_enc #(.NSH(NSRC - 1), .VW(VW)) u_enc (
        .pend (flag_d[NSRC-1:1] & src_ie[NSRC-1:1]),
        .code (enc_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vec_q <= '0;
        else
            vec_q <= enc_code;
    end

    assign flags      = flag_q;
    assign vec_out    = vec_q;
    assign irq_ch0    = gie & src_ie[0] & flag_q[0];
    assign irq_shared = gie & (|(flag_q[NSRC-1:1] & src_ie[NSRC-1:1]));

    // R7: an undisturbed access removes at most one shared flag
    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_acc && set_vec == '0 && !sw_flag_wr) |=>
        ($countones(flag_q[NSRC-1:1]) + 1 >= $countones($past(flag_q[NSRC-1:1]))));

    // R10: a vector access leaves the dedicated flag alone
    a_r10_ch0_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_acc && !ch0_ack && !set_vec[0] && !sw_flag_wr) |=> $stable(flag_q[0]));

    // R6: with steady enables the vector is nonzero exactly when a shared source is pending
    a_r6_vec_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(src_ie) |-> ((vec_q != '0) == (|(flag_q[NSRC-1:1] & src_ie[NSRC-1:1]))));

endmodule

// File: tb/test_tmr_irq_vector.sv
`timescale 1ns/1ps
module test_tmr_irq_vector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cap_evt = '0, cmp_evt = '0;
    logic       ovf_evt = 1'b0, sw_flag_wr = 1'b0, gie = 1'b0;
    logic [7:0] sw_flag_wdata = '0, src_ie = '0;
    logic       ch0_ack = 1'b0, vec_acc = 1'b0;
    logic [7:0] flags;
    logic [3:0] vec_out;
    logic       irq_ch0, irq_shared;

    int n_tests = 0, n_fail = 0;
    logic [7:0] m_flags = '0;
    logic [3:0] m_vec = '0;

    always #2.5 clk = ~clk;

    tmr_irq_vector i_tmr_irq_vector (
        .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cmp_evt(cmp_evt),
        .ovf_evt(ovf_evt), .sw_flag_wr(sw_flag_wr), .sw_flag_wdata(sw_flag_wdata),
        .src_ie(src_ie), .gie(gie), .ch0_ack(ch0_ack), .vec_acc(vec_acc),
        .flags(flags), .vec_out(vec_out), .irq_ch0(irq_ch0), .irq_shared(irq_shared)
    );

    function automatic logic [3:0] enc(input logic [7:0] f, input logic [7:0] ie);
        for (int k = 1; k <= 7; k++)
            if (f[k] & ie[k]) return 4'(2 * k);
        return 4'd0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance the model by one edge using the inputs currently driven
    task automatic step();
        logic [7:0] setv, nxt;
        setv = {ovf_evt, cap_evt | cmp_evt};
        for (int k = 0; k < 8; k++) begin
            logic clr;
            clr = (k == 0) ? ch0_ack : (vec_acc && m_vec == 4'(2 * k));
            if (setv[k])          nxt[k] = 1'b1;
            else if (sw_flag_wr)  nxt[k] = sw_flag_wdata[k];
            else if (clr)         nxt[k] = 1'b0;
            else                  nxt[k] = m_flags[k];
        end
        m_vec   = enc(nxt, src_ie);
        m_flags = nxt;
        @(posedge clk);
        @(negedge clk);
        check("R2 R3 R5 R7 R8 R9 R10 flags", flags, m_flags);
        check("R6 vector", vec_out, m_vec);
        check("R4 dedicated request", irq_ch0, gie & src_ie[0] & m_flags[0]);
        check("R4 shared request", irq_shared, gie & (|(m_flags[7:1] & src_ie[7:1])));
    endtask

    task automatic idle();
        cap_evt = '0; cmp_evt = '0; ovf_evt = 0; sw_flag_wr = 0;
        ch0_ack = 0; vec_acc = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 flags", flags, 0);
        check("R1 vector", vec_out, 0);
        check("R1 requests", {irq_ch0, irq_shared}, 0);
        rst_n = 1'b1;
        src_ie = 8'hFF; gie = 1'b1;
        @(negedge clk);

        // R7: channels 1 and 2 pending, one access clears only channel 1
        cap_evt = 7'b0000110; step(); idle();
        step();
        check("R6 two pending", vec_out, 2);
        vec_acc = 1; step(); idle();
        check("R7 ch1 cleared ch2 kept", flags, 8'b0000_0100);
        check("R7 vector moves on", vec_out, 4);
        check("R7 shared reasserts", irq_shared, 1);

        // R8: access clearing channel 2 while channel 2 sets again
        vec_acc = 1; cmp_evt = 7'b0000100; step(); idle();
        check("R8 set beats access", flags[2], 1);

        // R6: overflow only -> 14; disabled channel ignored
        sw_flag_wr = 1; sw_flag_wdata = 8'b1000_1000; src_ie = 8'b1111_0111; step(); idle();
        step();
        check("R6 overflow code, disabled ch3 ignored", vec_out, 14);
        check("R3 write loaded", flags, 8'b1000_1000);

        // R5/R10: ack clears ch0 only; access does not touch ch0
        src_ie = 8'hFF;
        cap_evt = 7'b0000001; step(); idle();
        vec_acc = 1; step(); idle();
        check("R10 ch0 kept after access", flags[0], 1);
        ch0_ack = 1; step(); idle();
        check("R5 ack clears ch0", flags[0], 0);

        // R9: write of 1 beats ack on ch0
        ch0_ack = 1; sw_flag_wr = 1; sw_flag_wdata = 8'h01; step(); idle();
        check("R9 write beats ack", flags[0], 1);

        // random phase
        for (int c = 0; c < 3000; c++) begin
            for (int k = 0; k < 7; k++) begin
                cap_evt[k] = ($urandom % 10) == 0;
                cmp_evt[k] = ($urandom % 12) == 0;
            end
            ovf_evt       = ($urandom % 15) == 0;
            sw_flag_wr    = ($urandom % 20) == 0;
            sw_flag_wdata = 8'($urandom);
            ch0_ack       = ($urandom % 4) == 0;
            vec_acc       = ($urandom % 3) == 0;
            if (($urandom % 16) == 0) src_ie = 8'($urandom) | 8'h81;
            gie           = ($urandom % 8) != 0;
            step();
        end
        idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule